// File: doc/BRIEF.md
# Single-to-Half Precision Rounding Converter

The block narrows a 32-bit binary floating-point operand to a 16-bit half-precision result in one registered stage. Each accepted operand produces the packed half word and four sticky-style exception indications: invalid, overflow, underflow and inexact. The result and flags appear one clock after the operand is presented with its valid strobe.

Per-operation controls choose one of five rounding directions, whether tininess is judged before or after rounding, whether subnormal inputs are flushed to zero, and whether NaN results collapse to a single default encoding. A format select picks standard half precision or an alternative half format. The alternative format has no NaN or infinity encodings, so its top exponent code is a normal exponent. NaN inputs become a signed zero, and infinities or overflows saturate to the largest finite value. Each of these cases raises invalid.

Top module: `f2h_cvt`

## Requirements
- R1: `valid_o` rises exactly one clock after a cycle with `valid_i` high. In a cycle without `valid_i` the next `valid_o` is low and `res_o` with all flags holds its value. After reset all outputs are zero.
- R2: A finite input that fits the half format exactly converts with no flag. Example: 0x3F800000 gives 0x3C00.
- R3: `rnd_mode_i` encodes 0 nearest-even, 1 nearest ties-away, 2 toward +infinity, 3 toward -infinity, 4 toward zero. The inexact flag (`flag_inexact_o`) is set whenever nonzero bits are discarded.
- R4: Results below the smallest normal are rounded at the subnormal position. A rounding carry turns the largest subnormal into the smallest normal, 0x0400.
- R5: `tiny_after_i`=0 judges tininess from the exponent before rounding. `tiny_after_i`=1 judges it after rounding with unbounded exponent. Underflow is raised only for a result that is both tiny and inexact.
- R6: In standard mode (`alt_fmt_i`=0), a rounded magnitude at or above 0x7C00 returns the signed infinity and raises overflow and inexact.
- R7: In alternative mode (`alt_fmt_i`=1), exponent code 31 is an ordinary normal. A magnitude at or above 0x8000, or an infinity input, returns the signed value 0x7FFF in bits 14:0 and raises invalid only.
- R8: In alternative mode a NaN input returns zero with the input sign and raises invalid.
- R9: In standard mode an infinity input returns the signed half infinity (exponent 31, fraction 0) with no flag.
- R10: In standard mode a NaN keeps its sign and the top 10 fraction bits, with fraction bit 9 forced to 1. A signaling NaN (input fraction bit 22 clear) raises invalid. With `dflt_nan_i`=1 every NaN result is 0x7E00.
- R11: With `ftz_in_i`=1 a subnormal input is treated as a signed zero and raises no flag.
- R12: Magnitudes below half the smallest subnormal round to signed zero, unless the directed mode points away from zero, which gives 0x0001 magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand strobe |
| op_i | input | 32 | Single-precision operand |
| rnd_mode_i | input | 3 | Rounding direction |
| alt_fmt_i | input | 1 | 1 selects the alternative half format |
| tiny_after_i | input | 1 | 1 selects tininess after rounding |
| ftz_in_i | input | 1 | Flush subnormal inputs to zero |
| dflt_nan_i | input | 1 | Force default NaN result |
| valid_o | output | 1 | Result strobe |
| res_o | output | 16 | Half-precision result |
| flag_invalid_o | output | 1 | Invalid operation |
| flag_overflow_o | output | 1 | Overflow |
| flag_underflow_o | output | 1 | Underflow |
| flag_inexact_o | output | 1 | Inexact |

## Verification
Random operands are spread over the whole exponent range and also concentrated on the bands near the half subnormal boundary and near the overflow edge. In those bands the shift amount, the carry into the exponent and the tininess choice all decide the result. Every random vector also draws a random rounding mode, format and control setting, so the five rounding directions are separated on the same kinds of operands. Directed operands cover the cases random draws rarely hit:
- an exact half-ulp tie, which separates nearest-even from ties-away;
- a negative sticky-only remainder, which separates the two directed modes;
- the all-ones value just under the smallest normal, which flips underflow between the two tininess choices;
- the value 2^16, which overflows one format but not the other;
- NaN and infinity in both formats.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int IN_EXP_W   = 8;
  localparam int IN_FRAC_W  = 23;
  localparam int OUT_EXP_W  = 5;
  localparam int OUT_FRAC_W = 10;
  localparam int IN_W       = 1 + IN_EXP_W + IN_FRAC_W;
  localparam int OUT_W      = 1 + OUT_EXP_W + OUT_FRAC_W;
  localparam int SIG_W      = IN_FRAC_W + 1;
  localparam int DROP_W     = IN_FRAC_W - OUT_FRAC_W;
  localparam int IN_BIAS    = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS   = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF  = IN_BIAS - OUT_BIAS;
  localparam int HE_W       = IN_EXP_W + 2;
  localparam int MAG_W      = HE_W + OUT_FRAC_W;
  localparam int SH_MAX     = SIG_W + 2;
  localparam int SH_W       = $clog2(SH_MAX + 1);

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_NEAR_AWAY = 3'd1,
    RM_TO_POS    = 3'd2,
    RM_TO_NEG    = 3'd3,
    RM_TO_ZERO   = 3'd4
  } rnd_mode_e;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_FINITE,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } in_cls_e;

  // increment decision from lsb, guard and sticky
  function automatic logic round_up(logic [2:0] mode, logic sign, logic lsb,
                                    logic guard, logic sticky);
    logic r;
    case (mode)
      RM_NEAR_EVEN: r = guard & (sticky | lsb);
      RM_NEAR_AWAY: r = guard;
      RM_TO_POS:    r = ~sign & (guard | sticky);
      RM_TO_NEG:    r = sign & (guard | sticky);
      default:      r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/f2h_unpack.sv
module f2h_unpack
  import f2h_pkg::*;
(
  input  logic [IN_W-1:0]        op_i,
  input  logic                   ftz_in_i,
  output logic                   sign_o,
  output in_cls_e                cls_o,
  output logic signed [HE_W-1:0] he_o,
  output logic [SIG_W-1:0]       sig_o,
  output logic [OUT_FRAC_W-2:0]  nan_pay_o
);
  logic [IN_EXP_W-1:0]  exp_f;
  logic [IN_FRAC_W-1:0] frac_f;
  logic                 exp_max, exp_zero, frac_zero;

  assign sign_o    = op_i[IN_W-1];
  assign exp_f     = op_i[IN_W-2 -: IN_EXP_W];
  assign frac_f    = op_i[IN_FRAC_W-1:0];
  assign exp_max   = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac_f;
  assign nan_pay_o = frac_f[IN_FRAC_W-2 -: OUT_FRAC_W-1];

  always_comb begin
    if (exp_max)
      cls_o = frac_zero ? CLS_INF : (frac_f[IN_FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
    else if (exp_zero && (frac_zero || ftz_in_i))
      cls_o = CLS_ZERO;
    else
      cls_o = CLS_FINITE;
  end

  // biased half exponent; a subnormal input uses exponent 1 and no hidden bit
  always_comb begin
    if (exp_zero) he_o = HE_W'(1 - BIAS_DIFF);
    else          he_o = HE_W'(int'(exp_f) - BIAS_DIFF);
  end

  assign sig_o = {~exp_zero, frac_f};
endmodule

// File: rtl/f2h_round.sv
module f2h_round
  import f2h_pkg::*;
(
  input  logic                   sign_i,
  input  logic signed [HE_W-1:0] he_i,
  input  logic [SIG_W-1:0]       sig_i,
  input  logic [2:0]             rnd_mode_i,
  input  logic                   alt_fmt_i,
  input  logic                   tiny_after_i,
  output logic [OUT_W-2:0]       mag_o,
  output logic                   ovf_o,
  output logic                   inexact_o,
  output logic                   underflow_o
);
  localparam int EXT_W = SIG_W + SH_MAX;

  logic [SH_W-1:0]        sh;
  logic [EXT_W-1:0]       ext;
  logic [OUT_FRAC_W:0]    kept;
  logic                   guard, sticky, inc;
  logic [OUT_FRAC_W+1:0]  rounded;
  logic [MAG_W-1:0]       base, mag_w, lim;
  logic                   is_sub, norm_bump, tiny;

  assign is_sub = (he_i < 1);

  always_comb begin
    int sh_int;
    sh_int = is_sub ? (DROP_W + 1 - int'(he_i)) : DROP_W;
    if (sh_int > SH_MAX) sh_int = SH_MAX;
    sh = SH_W'(sh_int);
  end

  assign ext    = {sig_i, {SH_MAX{1'b0}}} >> sh;
  assign kept   = ext[SH_MAX +: OUT_FRAC_W+1];
  assign guard  = ext[SH_MAX-1];
  assign sticky = |ext[SH_MAX-2:0];
  assign inc    = round_up(rnd_mode_i, sign_i, kept[0], guard, sticky);
  assign rounded = {1'b0, kept} + (OUT_FRAC_W+2)'(inc);

  // exponent field minus one; the hidden bit of rounded carries it up
  assign base  = is_sub ? '0 : MAG_W'(he_i - 1);
  assign mag_w = (base << OUT_FRAC_W) + MAG_W'(rounded);

  assign lim = alt_fmt_i ? (MAG_W'(1) << (OUT_W - 1))
                         : (MAG_W'((1 << OUT_EXP_W) - 1) << OUT_FRAC_W);
  assign ovf_o = (mag_w >= lim);

  // carry at normal precision decides after-rounding tininess at he == 0
  assign norm_bump = (&sig_i[SIG_W-1:DROP_W]) &
                     round_up(rnd_mode_i, sign_i, sig_i[DROP_W], sig_i[DROP_W-1],
                              |sig_i[DROP_W-2:0]);
  assign tiny = is_sub & (~tiny_after_i | (he_i < 0) | ~norm_bump);

  assign inexact_o   = guard | sticky;
  assign underflow_o = tiny & inexact_o;
  assign mag_o       = mag_w[OUT_W-2:0];

  always_comb begin
    if (is_sub) begin
      a_r4_sub_bound: assert (rounded <= (OUT_FRAC_W+2)'(1 << OUT_FRAC_W));
    end
  end
endmodule

// File: rtl/f2h_cvt.sv
module f2h_cvt
  import f2h_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   op_i,
  input  logic [2:0]        rnd_mode_i,
  input  logic              alt_fmt_i,
  input  logic              tiny_after_i,
  input  logic              ftz_in_i,
  input  logic              dflt_nan_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  res_o,
  output logic              flag_invalid_o,
  output logic              flag_overflow_o,
  output logic              flag_underflow_o,
  output logic              flag_inexact_o
);
  localparam logic [OUT_W-2:0] MAG_INF  = {{OUT_EXP_W{1'b1}}, {OUT_FRAC_W{1'b0}}};
  localparam logic [OUT_W-2:0] MAG_MAXA = '1;
  localparam logic [OUT_W-1:0] DFLT_NAN = {1'b0, {OUT_EXP_W{1'b1}}, 1'b1, {(OUT_FRAC_W-1){1'b0}}};

  logic                   sign;
  in_cls_e                cls;
  logic signed [HE_W-1:0] he;
  logic [SIG_W-1:0]       sig;
  logic [OUT_FRAC_W-2:0]  nan_pay;
  logic [OUT_W-2:0]       rnd_mag;
  logic                   rnd_ovf, rnd_inx, rnd_unf;

  logic [OUT_W-1:0]       res_d;
  logic                   inv_d, ovf_d, unf_d, inx_d;

  f2h_unpack u_unpack (
    .op_i      (op_i),
    .ftz_in_i  (ftz_in_i),
    .sign_o    (sign),
    .cls_o     (cls),
    .he_o      (he),
    .sig_o     (sig),
    .nan_pay_o (nan_pay)
  );

  f2h_round u_round (
    .sign_i       (sign),
    .he_i         (he),
    .sig_i        (sig),
    .rnd_mode_i   (rnd_mode_i),
    .alt_fmt_i    (alt_fmt_i),
    .tiny_after_i (tiny_after_i),
    .mag_o        (rnd_mag),
    .ovf_o        (rnd_ovf),
    .inexact_o    (rnd_inx),
    .underflow_o  (rnd_unf)
  );

  always_comb begin
    res_d = {sign, {(OUT_W-1){1'b0}}};
    inv_d = 1'b0;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    inx_d = 1'b0;
    case (cls)
      CLS_ZERO: ;
      CLS_INF: begin
        res_d = {sign, alt_fmt_i ? MAG_MAXA : MAG_INF};
        inv_d = alt_fmt_i;
      end
      CLS_QNAN, CLS_SNAN: begin
        inv_d = alt_fmt_i | (cls == CLS_SNAN);
        if (!alt_fmt_i)
          res_d = dflt_nan_i ? DFLT_NAN
                             : {sign, {OUT_EXP_W{1'b1}}, 1'b1, nan_pay};
      end
      default: begin
        if (rnd_ovf) begin
          res_d = {sign, alt_fmt_i ? MAG_MAXA : MAG_INF};
          inv_d = alt_fmt_i;
          ovf_d = ~alt_fmt_i;
          inx_d = ~alt_fmt_i;
        end else begin
          res_d = {sign, rnd_mag};
          unf_d = rnd_unf;
          inx_d = rnd_inx;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o          <= 1'b0;
      res_o            <= '0;
      flag_invalid_o   <= 1'b0;
      flag_overflow_o  <= 1'b0;
      flag_underflow_o <= 1'b0;
      flag_inexact_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o            <= res_d;
        flag_invalid_o   <= inv_d;
        flag_overflow_o  <= ovf_d;
        flag_underflow_o <= unf_d;
        flag_inexact_o   <= inx_d;
      end
    end
  end

  a_r1_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o)));
  a_r5_unf_inx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_underflow_o |-> flag_inexact_o);
  a_r6_ovf_inf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_overflow_o |-> (res_o[OUT_W-2:0] == MAG_INF && flag_inexact_o));
  a_r7_alt_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && alt_fmt_i) |=> !flag_overflow_o);
  a_r8_alt_nan_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && alt_fmt_i && (&op_i[IN_W-2 -: IN_EXP_W]) && (|op_i[IN_FRAC_W-1:0]))
    |=> (res_o[OUT_W-2:0] == '0 && flag_invalid_o));
endmodule

// File: tb/f2h_cvt_bench.sv
`timescale 1ns/1ps
module f2h_cvt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic [2:0]  rnd_mode_i = '0;
  logic        alt_fmt_i = 1'b0, tiny_after_i = 1'b0, ftz_in_i = 1'b0, dflt_nan_i = 1'b0;
  logic        valid_o;
  logic [15:0] res_o;
  logic        inv_o, ovf_o, unf_o, inx_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  f2h_cvt u_f2h_cvt (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .rnd_mode_i(rnd_mode_i), .alt_fmt_i(alt_fmt_i), .tiny_after_i(tiny_after_i),
    .ftz_in_i(ftz_in_i), .dflt_nan_i(dflt_nan_i), .valid_o(valid_o), .res_o(res_o),
    .flag_invalid_o(inv_o), .flag_overflow_o(ovf_o),
    .flag_underflow_o(unf_o), .flag_inexact_o(inx_o)
  );

  function automatic logic rdec(logic [2:0] md, logic s, logic lsb, longint rem, longint half);
    case (md)
      3'd0: return (rem > half) || (rem == half && lsb);
      3'd1: return rem >= half;
      3'd2: return !s && rem != 0;
      3'd3: return s && rem != 0;
      default: return 1'b0;
    endcase
  endfunction

  // {res[15:0], invalid, overflow, underflow, inexact}
  function automatic logic [19:0] ref_cvt(logic [31:0] op, logic [2:0] md, logic alt,
                                          logic ta, logic ftz, logic dn);
    logic s, up, up2, inx, tiny, bump;
    int e, ex, u, d;
    longint f, sig, q, rem, half, q2, rem2, mag, lim;
    logic [15:0] r;
    s = op[31];
    e = int'(op[30:23]);
    f = longint'(op[22:0]);
    if (e == 255) begin
      if (f != 0) begin
        if (alt) return {s, 15'h0, 4'b1000};
        r = dn ? 16'h7E00 : {s, 5'h1F, 1'b1, op[21:13]};
        return {r, !op[22], 3'b000};
      end
      if (alt) return {s, 15'h7FFF, 4'b1000};
      return {s, 15'h7C00, 4'b0000};
    end
    if (e == 0 && (f == 0 || ftz)) return {s, 15'h0, 4'b0000};
    sig = (e == 0) ? f : (f | (64'sd1 << 23));
    ex  = (e == 0) ? -126 : e - 127;
    u   = ((ex < -14) ? -14 : ex) - 10;
    d   = u - (ex - 23);
    if (d > 40) d = 40;
    q    = sig >> d;
    rem  = sig & ((64'sd1 << d) - 1);
    half = 64'sd1 << (d - 1);
    up   = rdec(md, s, q[0], rem, half);
    inx  = (rem != 0);
    q    = q + longint'(up);
    mag  = (ex >= -14) ? ((longint'(ex + 14) << 10) + q) : q;
    lim  = alt ? 64'sh8000 : 64'sh7C00;
    if (mag >= lim) begin
      if (alt) return {s, 15'h7FFF, 4'b1000};
      return {s, 15'h7C00, 4'b0101};
    end
    q2   = sig >> 13;
    rem2 = sig & 64'sd8191;
    up2  = rdec(md, s, q2[0], rem2, 64'sd4096);
    bump = (q2 + longint'(up2)) >= 64'sd2048;
    tiny = (ex < -14) && (!ta || ex < -15 || !bump);
    return {s, mag[14:0], 1'b0, 1'b0, tiny && inx, inx};
  endfunction

  task automatic check(string tag, logic [19:0] got, logic [19:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%05h exp=%05h", tag, got, exp);
    end
  endtask

  task automatic run(string tag, logic [31:0] op, logic [2:0] md, logic alt, logic ta,
                     logic ftz, logic dn, logic [19:0] exp);
    @(negedge clk);
    op_i = op; rnd_mode_i = md; alt_fmt_i = alt; tiny_after_i = ta;
    ftz_in_i = ftz; dflt_nan_i = dn; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({tag, " valid"}, {19'h0, valid_o}, 20'h1);
    check(tag, {res_o, inv_o, ovf_o, unf_o, inx_o}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog got=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [19:0] last;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {res_o, inv_o, ovf_o, unf_o, inx_o, valid_o}, 21'h0);
    rst_n = 1'b1;
    run("R2 one",           32'h3F800000, 3'd0, 0, 0, 0, 0, {16'h3C00, 4'b0000});
    run("R3 tie even",      32'h3F801000, 3'd0, 0, 0, 0, 0, {16'h3C00, 4'b0001});
    run("R3 tie away",      32'h3F801000, 3'd1, 0, 0, 0, 0, {16'h3C01, 4'b0001});
    run("R3 neg down",      32'hBF800800, 3'd3, 0, 0, 0, 0, {16'hBC01, 4'b0001});
    run("R3 neg up",        32'hBF800800, 3'd2, 0, 0, 0, 0, {16'hBC00, 4'b0001});
    run("R4 R5 carry before", 32'h387FFFFF, 3'd0, 0, 0, 0, 0, {16'h0400, 4'b0011});
    run("R5 carry after",   32'h387FFFFF, 3'd0, 0, 1, 0, 0, {16'h0400, 4'b0001});
    run("R6 ieee ovf",      32'h47800000, 3'd0, 0, 0, 0, 0, {16'h7C00, 4'b0101});
    run("R6 ieee rtz edge", 32'h477FF000, 3'd4, 0, 0, 0, 0, {16'h7BFF, 4'b0001});
    run("R6 ieee rne edge", 32'h477FF000, 3'd0, 0, 0, 0, 0, {16'h7C00, 4'b0101});
    run("R7 alt range",     32'h47800000, 3'd0, 1, 0, 0, 0, {16'h7C00, 4'b0000});
    run("R7 alt ovf",       32'hC8000000, 3'd0, 1, 0, 0, 0, {16'hFFFF, 4'b1000});
    run("R7 alt inf",       32'h7F800000, 3'd0, 1, 0, 0, 0, {16'h7FFF, 4'b1000});
    run("R8 alt nan",       32'hFFC00000, 3'd0, 1, 0, 0, 0, {16'h8000, 4'b1000});
    run("R9 ieee inf",      32'hFF800000, 3'd0, 0, 0, 0, 0, {16'hFC00, 4'b0000});
    run("R10 snan",         32'h7F800001, 3'd0, 0, 0, 0, 0, {16'h7E00, 4'b1000});
    run("R10 qnan pay",     32'hFFC12345, 3'd0, 0, 0, 0, 0, {16'hFE09, 4'b0000});
    run("R10 dflt nan",     32'hFFC12345, 3'd0, 0, 0, 0, 1, {16'h7E00, 4'b0000});
    run("R11 denorm kept",  32'h00000001, 3'd2, 0, 0, 0, 0, {16'h0001, 4'b0011});
    run("R11 denorm flush", 32'h00000001, 3'd2, 0, 0, 1, 0, {16'h0000, 4'b0000});
    run("R12 tiny tie",     32'h33000000, 3'd0, 0, 0, 0, 0, {16'h0000, 4'b0011});
    run("R12 tiny above",   32'h33000001, 3'd0, 0, 0, 0, 0, {16'h0001, 4'b0011});
    run("R12 neg tiny rtz", 32'hB3000001, 3'd4, 0, 0, 0, 0, {16'h8000, 4'b0011});
    // R1 idle cycle holds outputs
    last = {res_o, inv_o, ovf_o, unf_o, inx_o};
    op_i = 32'h3F800000;
    @(negedge clk);
    check("R1 idle valid", {19'h0, valid_o}, 20'h0);
    check("R1 idle hold", {res_o, inv_o, ovf_o, unf_o, inx_o}, last);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] op;
      logic [7:0]  ex;
      logic [2:0]  md;
      logic        alt, ta, ftz, dn;
      op = $urandom();
      case ($urandom() % 4)
        0: ex = op[30:23];
        1: ex = 8'(95 + $urandom() % 52);
        2: ex = 8'(100 + $urandom() % 14);
        default: ex = 8'(140 + $urandom() % 6);
      endcase
      if ($urandom() % 8 == 0) op[12:0] = ($urandom() % 2) ? 13'h1000 : 13'h1FFF;
      if ($urandom() % 16 == 0) ex = ($urandom() % 2) ? 8'hFF : 8'h00;
      op[30:23] = ex;
      md  = 3'($urandom() % 5);
      alt = 1'($urandom()); ta = 1'($urandom());
      ftz = 1'($urandom()); dn = 1'($urandom());
      run("R2 R3 R4 R5 random", op, md, alt, ta, ftz, dn, ref_cvt(op, md, alt, ta, ftz, dn));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule